// File: doc/BRIEF.md
# Boot Source Selection Controller

This controller decides where a processor subsystem fetches its second-stage boot image. When cold reset is released it captures, once, a 3-bit strap from the select pins along with a fuse that forces FPGA boot and two clock-select fuse bits. It turns these into a resolved source code, and it enables at most one flash interface. It also reports whether clock configuration comes from the fuses or from the fabric.

When the fabric is the source, the controller first waits for the FPGA to report user mode. Only then does it look at the fabric's ready and failure flags, with a cycle timeout that software can program. Warm reset restarts this handshake but does not resample the strap. A bit that software can write asks the next warm boot to run from on-chip RAM. All captured values and status are packed into a read-only 16-bit information word.

Top module: `boot_src_sel`

## Requirements
- R1: Pins and fuses are captured on the first clock after cold reset is released and are never captured again. A warm reset, or a change on the pins afterwards, leaves the captured values unchanged.
- R2: When the captured FPGA-boot fuse is 1, the source is FPGA whatever the pins hold, including the reserved value 0.
- R3: With the fuse at 0, the strap maps to the source code (0 none, 1 FPGA, 2 NAND, 3 SD/MMC, 4 quad SPI, 5 RAM) as follows: strap 1 gives FPGA, 2 and 3 give NAND, 4 and 5 give SD/MMC, 6 and 7 give quad SPI.
- R4: When the captured source is FPGA, `clk_from_fabric` is 1 and `clk_sel_eff` is 0. Otherwise `clk_from_fabric` is 0 and `clk_sel_eff` carries the captured clock fuses.
- R5: In an FPGA boot, the ready and failure flags are ignored until the synchronized user-mode flag has been seen.
- R6: In an FPGA boot, ready seen after user mode sets the handshake-done status.
- R7: `flash_en` bit 0 enables NAND, bit 1 SD/MMC and bit 2 quad SPI. Exactly the bit for the current flash source is set, and all bits are 0 for FPGA, RAM or none.
- R8: A write of 1 to the RAM-request bit does not change the source until the next warm reset. From that warm reset on, the source is RAM (5).
- R9: Strap 0 with the fuse at 0 sets the select-error status, and the source is none (0).
- R10: When neither ready nor failure arrives within `hs_timeout_cyc` cycles after user mode is seen, the timeout status is set.
- R11: A failure flag after user mode sets the failure status and ends the wait. It takes priority over a ready flag seen in the same cycle.
- R12: `boot_info` layout: [2:0] strap, [3] FPGA-boot fuse, [5:4] clock fuses, [8:6] source code, [9] handshake done, [10] failure, [11] timeout, [12] select error, [13] clock from fabric, [14] RAM boot active, [15] zero. At most one of bits 9 to 11 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous |
| sel_pins | input | 3 | Boot-select strap |
| fuse_fpga_boot | input | 1 | Fuse that forces FPGA boot |
| fuse_clk_sel | input | 2 | Clock-select fuse bits |
| fpga_user_mode | input | 1 | FPGA is in user mode (asynchronous) |
| fab_ready | input | 1 | Fabric ready flag (asynchronous) |
| fab_fail | input | 1 | Fabric failure flag (asynchronous) |
| ram_req_we | input | 1 | Write strobe for the RAM-request bit |
| ram_req_wd | input | 1 | Write data for the RAM-request bit |
| hs_timeout_cyc | input | TO_W | Handshake timeout in cycles |
| boot_info | output | 16 | Read-only information word |
| boot_src | output | 3 | Resolved source code |
| clk_from_fabric | output | 1 | Clock configuration comes from the fabric |
| clk_sel_eff | output | 2 | Clock fuses in effect |
| flash_en | output | 3 | Flash interface enables |

## Verification
The bench first walks every strap value, with the fuse clear and with it set, and checks the source, the flash enables and the clock flag. A decoder that mapped a reserved or voltage variant to the wrong interface would show up there, as would one that let the pins override the fuse. Directed cases then change the pins and pulse warm reset, to catch a design that resamples the strap on warm reset. They hold ready high before user mode, which catches a handshake that skips the user-mode wait. They also raise ready and failure together, where a design with the wrong priority would report success. A short timeout is checked both before and after it expires, which catches an off-by-a-lot counter. Finally, a RAM request is written and checked before and after a warm reset, which catches a redirect that acts at once instead of waiting for that reset.

// File: rtl/boot_src_sel.sv
module boot_src_sel #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            cold_rst_n,
  input  logic            warm_rst_n,
  input  logic [2:0]      sel_pins,
  input  logic            fuse_fpga_boot,
  input  logic [1:0]      fuse_clk_sel,
  input  logic            fpga_user_mode,
  input  logic            fab_ready,
  input  logic            fab_fail,
  input  logic            ram_req_we,
  input  logic            ram_req_wd,
  input  logic [TO_W-1:0] hs_timeout_cyc,
  output logic [15:0]     boot_info,
  output logic [2:0]      boot_src,
  output logic            clk_from_fabric,
  output logic [1:0]      clk_sel_eff,
  output logic [2:0]      flash_en
);
  localparam logic [2:0] SRC_NONE = 3'd0, SRC_FPGA = 3'd1, SRC_NAND = 3'd2,
                         SRC_SD = 3'd3, SRC_QSPI = 3'd4, SRC_RAM = 3'd5;

  typedef enum logic [2:0] {ST_IDLE, ST_WAIT_UM, ST_WAIT_HS, ST_OK, ST_FAIL, ST_TMO} hs_st_t;

  logic            captured, fz_fpga, ram_req, ram_active;
  logic [2:0]      raw_sel;
  logic [1:0]      fz_clk;
  logic [2:0]      latched_src;
  logic [2:0]      sync1, sync2;
  logic [TO_W-1:0] cnt;
  hs_st_t          st;
  logic            run_rst_n, sel_err;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      captured <= 1'b0;
      raw_sel  <= '0;
      fz_fpga  <= 1'b0;
      fz_clk   <= '0;
      ram_req  <= 1'b0;
      ram_active <= 1'b0;
    end else begin
      if (!captured) begin
        captured <= 1'b1;
        raw_sel  <= sel_pins;
        fz_fpga  <= fuse_fpga_boot;
        fz_clk   <= fuse_clk_sel;
      end
      if (ram_req_we) ram_req <= ram_req_wd;
      if (!warm_rst_n) ram_active <= ram_req;
    end
  end

  always_comb begin
    if (!captured)    latched_src = SRC_NONE;
    else if (fz_fpga) latched_src = SRC_FPGA;
    else begin
      case (raw_sel)
        3'd1:       latched_src = SRC_FPGA;
        3'd2, 3'd3: latched_src = SRC_NAND;
        3'd4, 3'd5: latched_src = SRC_SD;
        3'd6, 3'd7: latched_src = SRC_QSPI;
        default:    latched_src = SRC_NONE;
      endcase
    end
  end

  assign boot_src        = ram_active ? SRC_RAM : latched_src;
  assign clk_from_fabric = (latched_src == SRC_FPGA);
  assign clk_sel_eff     = clk_from_fabric ? 2'b00 : fz_clk;
  assign sel_err         = captured && !fz_fpga && (raw_sel == 3'd0);
  assign flash_en        = {boot_src == SRC_QSPI, boot_src == SRC_SD, boot_src == SRC_NAND};
  assign run_rst_n       = cold_rst_n & warm_rst_n;

  always_ff @(posedge clk or negedge run_rst_n) begin
    if (!run_rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {fab_fail, fab_ready, fpga_user_mode};
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge run_rst_n) begin
    if (!run_rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE:    if (boot_src == SRC_FPGA) st <= ST_WAIT_UM;
        ST_WAIT_UM: if (sync2[0]) begin
                      st  <= ST_WAIT_HS;
                      cnt <= '0;
                    end
        ST_WAIT_HS: begin
          if (sync2[2])                       st <= ST_FAIL;
          else if (sync2[1])                  st <= ST_OK;
          else if (cnt == hs_timeout_cyc - 1'b1) st <= ST_TMO;
          else                                cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign boot_info = {1'b0, ram_active, clk_from_fabric, sel_err,
                      st == ST_TMO, st == ST_FAIL, st == ST_OK,
                      boot_src, fz_clk, fz_fpga, raw_sel};
endmodule

module boot_src_sel_chk (
  input logic        clk,
  input logic        cold_rst_n,
  input logic        ram_active,
  input logic [15:0] boot_info,
  input logic [2:0]  boot_src,
  input logic        clk_from_fabric,
  input logic [1:0]  clk_sel_eff,
  input logic [2:0]  flash_en
);
  p_no_resample_r1: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (boot_info[8:6] != 3'd0 || boot_info[12]) |=> $stable(boot_info[5:0]));
  p_fuse_forces_fpga_r2: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (boot_info[3] && !ram_active) |-> boot_src == 3'd1);
  p_clk_fabric_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
    clk_from_fabric |-> clk_sel_eff == 2'b00);
  p_no_flash_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $onehot0(flash_en) && (boot_src inside {3'd0, 3'd1, 3'd5} -> flash_en == 3'b000));
  p_hs_only_fpga_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    boot_info[9] |-> clk_from_fabric);
  p_status_onehot_r12: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $onehot0(boot_info[11:9]));
  p_ram_src_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ram_active |-> boot_src == 3'd5);
endmodule

bind boot_src_sel boot_src_sel_chk u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .ram_active(ram_active),
  .boot_info(boot_info), .boot_src(boot_src), .clk_from_fabric(clk_from_fabric),
  .clk_sel_eff(clk_sel_eff), .flash_en(flash_en)
);

// File: tb/test_boot_src_sel.sv
module test_boot_src_sel;
  logic clk = 0, cold_rst_n = 0, warm_rst_n = 1;
  logic [2:0] sel_pins = 0;
  logic fuse_fpga_boot = 0;
  logic [1:0] fuse_clk_sel = 2'b10;
  logic fpga_user_mode = 0, fab_ready = 0, fab_fail = 0, ram_req_we = 0, ram_req_wd = 0;
  logic [15:0] hs_timeout_cyc = 16'd1000;
  logic [15:0] boot_info;
  logic [2:0] boot_src, flash_en;
  logic clk_from_fabric;
  logic [1:0] clk_sel_eff;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  boot_src_sel i_boot_src_sel (.*);

  // {fuse, sel, expected source, expected flash_en}
  localparam logic [9:0] VEC [9] = '{
    {1'b0, 3'd0, 3'd0, 3'b000}, {1'b0, 3'd1, 3'd1, 3'b000},
    {1'b0, 3'd2, 3'd2, 3'b001}, {1'b0, 3'd3, 3'd2, 3'b001},
    {1'b0, 3'd4, 3'd3, 3'b010}, {1'b0, 3'd5, 3'd3, 3'b010},
    {1'b0, 3'd6, 3'd4, 3'b100}, {1'b0, 3'd7, 3'd4, 3'b100},
    {1'b1, 3'd0, 3'd1, 3'b000}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cold_boot(input logic f, input logic [2:0] s);
    cold_rst_n = 0;
    fuse_fpga_boot = f;
    sel_pins = s;
    cyc(3);
    cold_rst_n = 1;
    cyc(3);
  endtask

  task automatic warm_pulse();
    warm_rst_n = 0;
    cyc(3);
    warm_rst_n = 1;
    cyc(3);
  endtask

  initial begin
    cyc(2);
    chk(boot_info == 16'h0 && boot_src == 0 && flash_en == 0, "R12 reset", boot_info, 0);

    for (int i = 0; i < 9; i++) begin
      logic [9:0] v;
      logic fpga;
      v = VEC[i];
      cold_boot(v[9], v[8:6]);
      fpga = (v[5:3] == 3'd1);
      chk(boot_src == v[5:3], v[9] ? "R2 fuse" : "R3 map", boot_src, v[5:3]);
      chk(flash_en == v[2:0], "R7 flash_en", flash_en, v[2:0]);
      chk(clk_from_fabric == fpga && clk_sel_eff == (fpga ? 2'b00 : 2'b10),
          "R4 clock", {clk_from_fabric, clk_sel_eff}, {fpga, fpga ? 2'b00 : 2'b10});
      chk(boot_info[12] == (v[9:6] == 4'd0), "R9 sel_err", boot_info[12], v[9:6] == 4'd0);
      chk(boot_info[5:0] == {2'b10, v[9:6]} && boot_info[8:6] == v[5:3] && boot_info[13] == fpga,
          "R12 fields", boot_info[13:0], {fpga, 1'b0, 3'b000, v[5:3], 2'b10, v[9:6]});
    end

    // R1: pins change, warm reset, nothing resampled
    cold_boot(1'b0, 3'd6);
    sel_pins = 3'd2;
    fuse_fpga_boot = 1;
    warm_pulse();
    chk(boot_info[3:0] == 4'h6 && boot_src == 3'd4, "R1 no resample", boot_info[3:0], 6);

    // R5, R6: ready before user mode ignored
    fab_ready = 1;
    cold_boot(1'b0, 3'd1);
    cyc(10);
    chk(boot_info[11:9] == 3'b000, "R5 wait user mode", boot_info[11:9], 0);
    fpga_user_mode = 1;
    cyc(8);
    chk(boot_info[11:9] == 3'b001, "R6 ready", boot_info[11:9], 1);

    // R11: failure wins over ready
    fab_fail = 1;
    warm_pulse();
    cyc(6);
    chk(boot_info[11:9] == 3'b010, "R11 fail priority", boot_info[11:9], 2);

    // R10: timeout
    fab_fail = 0;
    fab_ready = 0;
    hs_timeout_cyc = 16'd20;
    warm_pulse();
    cyc(4);
    chk(boot_info[11:9] == 3'b000, "R10 before expiry", boot_info[11:9], 0);
    cyc(30);
    chk(boot_info[11:9] == 3'b100, "R10 timeout", boot_info[11:9], 4);

    // R8: RAM request takes effect at warm reset only
    fpga_user_mode = 0;
    cold_boot(1'b0, 3'd3);
    @(negedge clk); ram_req_we = 1; ram_req_wd = 1;
    @(negedge clk); ram_req_we = 0;
    cyc(2);
    chk(boot_src == 3'd2 && flash_en == 3'b001, "R8 no early redirect", boot_src, 2);
    warm_pulse();
    chk(boot_src == 3'd5 && flash_en == 3'b000 && boot_info[14], "R8 ram boot", boot_src, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule